// File: doc/BRIEF.md
# Table-Driven 4-bit ADPCM Sample Decoder

This block turns a stream of 4-bit ADPCM codes into signed PCM samples. Two registers hold its state: a 4-bit step index (0 to 15) and a 16-bit two's-complement sample accumulator. Each accepted code does three things in order:

- it looks up an unsigned delta in a 16-row by 8-column table, using the current index and the low three code bits;
- it adds that delta to the accumulator, or subtracts it when code bit 3 is set;
- it moves the index by an amount set by the code magnitude, then clamps the index to the table.

A synchronous clear zeroes both registers. The upstream sequencer drives the clear when it meets a silence block. The output is the accumulator scaled by 128.

The upstream block presents one code per strobe. Conversion to other output rates and any filtering happen downstream of this block.

Top module: `adpcm_table_decoder`

## Requirements
- R1: While `rst_n` is low, `sample_out` is 0. After reset, the index and the accumulator both start at 0.
- R2: When code bit 3 is 1, the delta is subtracted from the accumulator. When bit 3 is 0, it is added. Codes 8 to 15 use the same table entry as the code with the same low three bits.
- R3: The delta for row i and magnitude m is round((A[m]*(256-W[i]) + B[m]*W[i]) / 256), with halves rounded up.
  - A = 0,0,1,2,3,5,7,10.
  - B = 6,20,36,54,76,104,144,214.
  - W = 0,3,7,12,18,25,33,43,55,69,86,107,132,162,201,256.
  - So row 0 equals A and row 15 equals B.
- R4: The index changes by -1,-1,0,0,+1,+2,+2,+3 for magnitudes 0 to 7. The sign bit does not affect this change.
- R5: After each update the index is clamped to the range 0 to 15.
- R6: The delta applied by a code comes from the index held before that code. The new index applies from the next code onward.
- R7: A cycle with `clear` high sets the accumulator and the index to 0.
- R8: When `clear` and `code_valid` are both high in the same cycle, the clear wins and the code is dropped.
- R9: The accumulator wraps modulo 2^16. `sample_out` is the low 16 bits of the accumulator times 128.
- R10: In a cycle with neither `code_valid` nor `clear` high, `code` is ignored and both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| code_valid | input | 1 | Strobe: accept `code` on this edge |
| code | input | 4 | ADPCM code; bit 3 is the sign, bits 2:0 the magnitude |
| clear | input | 1 | Synchronous zeroing of the sample and the index |
| sample_out | output | 16 | Accumulator scaled by 128 |

## Verification
The step index is not visible at the ports, so a wrong index only shows on the next accepted code. That code's delta comes from the wrong table row, and the change in `sample_out` differs from the model one edge after the strobe. A clamp fault needs the index to sit at 0 or 15 first. The random stream is therefore biased into long runs of large or small magnitudes, and directed runs pin each limit before probing it. Faults in the sign handling or in the clear priority show in the sample register on the very next edge.

// File: rtl/adpcm_dec_pkg.sv
package adpcm_dec_pkg;

  localparam int CODE_W     = 4;
  localparam int INDEX_W    = 4;
  localparam int NUM_ROWS   = 16;
  localparam int MAG_LEVELS = 8;
  localparam int DELTA_W    = 8;
  localparam int WEIGHT_ONE = 256;

  // Delta row at the smallest step index.
  function automatic int anchor_low(input int mag);
    case (mag)
      0: return 0;   1: return 0;   2: return 1;   3: return 2;
      4: return 3;   5: return 5;   6: return 7;   default: return 10;
    endcase
  endfunction

  // Delta row at the largest step index.
  function automatic int anchor_high(input int mag);
    case (mag)
      0: return 6;   1: return 20;  2: return 36;  3: return 54;
      4: return 76;  5: return 104; 6: return 144; default: return 214;
    endcase
  endfunction

  // Convex blend weight per row; Q8, 0 at row 0 and 256 at row 15.
  function automatic int row_weight(input int row);
    case (row)
      0:  return 0;   1:  return 3;   2:  return 7;   3:  return 12;
      4:  return 18;  5:  return 25;  6:  return 33;  7:  return 43;
      8:  return 55;  9:  return 69;  10: return 86;  11: return 107;
      12: return 132; 13: return 162; 14: return 201; default: return 256;
    endcase
  endfunction

  function automatic int row_delta(input int row, input int mag);
    int w;
    w = row_weight(row);
    return (anchor_low(mag) * (WEIGHT_ONE - w) + anchor_high(mag) * w
            + WEIGHT_ONE / 2) / WEIGHT_ONE;
  endfunction

  function automatic int index_adjust(input int mag);
    case (mag)
      0, 1:    return -1;
      2, 3:    return 0;
      4:       return 1;
      5, 6:    return 2;
      default: return 3;
    endcase
  endfunction

endpackage

// File: rtl/adpcm_delta_rom.sv
module adpcm_delta_rom
  import adpcm_dec_pkg::*;
#(
  parameter int ROWS   = NUM_ROWS,
  parameter int LEVELS = MAG_LEVELS,
  parameter int DW     = DELTA_W
) (
  input  logic [$clog2(ROWS)-1:0]   row_sel,
  input  logic [$clog2(LEVELS)-1:0] mag_sel,
  output logic [DW-1:0]             delta
);

  localparam int RW      = $clog2(ROWS);
  localparam int MW      = $clog2(LEVELS);
  localparam int ENTRIES = ROWS * LEVELS;

  logic [DW-1:0] table_q [ENTRIES];

  // Table contents are computed at elaboration from the two anchor rows.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar m = 0; m < LEVELS; m++) begin : g_mag
      assign table_q[r*LEVELS + m] = DW'(row_delta(r, m));
    end
  end

  assign delta = table_q[{row_sel, mag_sel}];

endmodule

// File: rtl/adpcm_index_step.sv
module adpcm_index_step
  import adpcm_dec_pkg::*;
#(
  parameter int IW = INDEX_W,
  parameter int MW = 3
) (
  input  logic [IW-1:0] idx_cur,
  input  logic [MW-1:0] mag,
  output logic [IW-1:0] idx_next
);

  localparam int IDX_MAX = (1 << IW) - 1;

  int sum;

  always_comb begin
    sum = int'(idx_cur) + index_adjust(int'(mag));
    if (sum < 0)
      idx_next = '0;
    else if (sum > IDX_MAX)
      idx_next = IW'(IDX_MAX);
    else
      idx_next = IW'(sum);
  end

endmodule

// File: rtl/adpcm_table_decoder.sv
module adpcm_table_decoder
  import adpcm_dec_pkg::*;
#(
  parameter int ACC_W     = 16,
  parameter int OUT_W     = 16,
  parameter int OUT_SHIFT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_valid,
  input  logic [CODE_W-1:0] code,
  input  logic              clear,
  output logic [OUT_W-1:0]  sample_out
);

  localparam int MAG_W    = CODE_W - 1;
  localparam int SCALED_W = ACC_W + OUT_SHIFT;

  // Reset synchronizer: assert asynchronously, release on the clock.
  logic rst_meta_q, rst_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_ok_q   <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_ok_q   <= rst_meta_q;
    end
  end

  logic [ACC_W-1:0]   acc_q, acc_nxt;
  logic [INDEX_W-1:0] idx_q, idx_nxt, idx_stepped;
  logic [DELTA_W-1:0] delta;
  logic [ACC_W-1:0]   delta_ext;
  logic [MAG_W-1:0]   mag;
  logic               sign_neg;
  logic               state_en;

  assign mag      = code[MAG_W-1:0];
  assign sign_neg = code[CODE_W-1];

  adpcm_delta_rom #(
    .ROWS  (NUM_ROWS),
    .LEVELS(MAG_LEVELS),
    .DW    (DELTA_W)
  ) u_rom (
    .row_sel(idx_q),
    .mag_sel(mag),
    .delta  (delta)
  );

  adpcm_index_step #(
    .IW(INDEX_W),
    .MW(MAG_W)
  ) u_step (
    .idx_cur (idx_q),
    .mag     (mag),
    .idx_next(idx_stepped)
  );

  assign delta_ext = ACC_W'(delta);
  assign state_en  = clear | code_valid;

  // Next-state logic; clear has priority over a strobe.
  always_comb begin
    acc_nxt = acc_q;
    idx_nxt = idx_q;
    if (clear) begin
      acc_nxt = '0;
      idx_nxt = '0;
    end else if (code_valid) begin
      acc_nxt = sign_neg ? (acc_q - delta_ext) : (acc_q + delta_ext);
      idx_nxt = idx_stepped;
    end
  end

  always_ff @(posedge clk or negedge rst_ok_q) begin
    if (!rst_ok_q) begin
      acc_q <= '0;
      idx_q <= '0;
    end else if (state_en) begin
      acc_q <= acc_nxt;
      idx_q <= idx_nxt;
    end
  end

  logic [SCALED_W-1:0] scaled;
  assign scaled     = {acc_q, {OUT_SHIFT{1'b0}}};
  assign sample_out = scaled[OUT_W-1:0];

  // Clear zeroes both state registers (R7, R8).
  assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_ok_q)
    clear |=> (acc_q == '0) && (idx_q == '0));

  // Idle cycles keep state (R10).
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_ok_q)
    (!clear && !code_valid) |=> ($stable(acc_q) && $stable(idx_q)));

  // Magnitudes 2 and 3 leave the index unchanged (R4).
  assert_idx_flat_R4: assert property (@(posedge clk) disable iff (!rst_ok_q)
    (code_valid && !clear && (mag == 3'd2 || mag == 3'd3)) |=> $stable(idx_q));

  // Index saturates at the top (R5).
  assert_idx_top_R5: assert property (@(posedge clk) disable iff (!rst_ok_q)
    (code_valid && !clear && idx_q == 4'd15 && mag >= 3'd4) |=> (idx_q == 4'd15));

  // Index saturates at the bottom (R5).
  assert_idx_bottom_R5: assert property (@(posedge clk) disable iff (!rst_ok_q)
    (code_valid && !clear && idx_q == 4'd0 && mag <= 3'd1) |=> (idx_q == 4'd0));

  // Magnitude 0 at row 0 carries a zero delta, old index used (R6).
  assert_row0_zero_R6: assert property (@(posedge clk) disable iff (!rst_ok_q)
    (code_valid && !clear && idx_q == 4'd0 && mag == 3'd0) |=> $stable(acc_q));

endmodule

// File: tb/adpcm_table_decoder_test.sv
`timescale 1ns/1ps
module adpcm_table_decoder_test;

  logic        clk;
  logic        rst_n;
  logic        code_valid;
  logic [3:0]  code;
  logic        clear;
  logic [15:0] sample_out;

  int checks;
  int fails;

  logic [15:0] m_acc;
  int          m_idx;

  adpcm_table_decoder uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .code_valid(code_valid),
    .code      (code),
    .clear     (clear),
    .sample_out(sample_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Model tables, taken from the requirement text.
  function automatic int t_low(input int m);
    int a[8] = '{0, 0, 1, 2, 3, 5, 7, 10};
    return a[m];
  endfunction
  function automatic int t_high(input int m);
    int b[8] = '{6, 20, 36, 54, 76, 104, 144, 214};
    return b[m];
  endfunction
  function automatic int t_w(input int i);
    int w[16] = '{0, 3, 7, 12, 18, 25, 33, 43, 55, 69, 86, 107, 132, 162, 201, 256};
    return w[i];
  endfunction
  function automatic int t_delta(input int i, input int m);
    return (t_low(m) * (256 - t_w(i)) + t_high(m) * t_w(i) + 128) / 256;
  endfunction
  function automatic int t_adj(input int m);
    int d[8] = '{-1, -1, 0, 0, 1, 2, 2, 3};
    return d[m];
  endfunction
  function automatic logic [15:0] t_out(input logic [15:0] acc);
    return 16'(acc << 7);
  endfunction

  task automatic model_apply(input logic v, input logic [3:0] c, input logic clr);
    int d;
    if (clr) begin
      m_acc = '0;
      m_idx = 0;
    end else if (v) begin
      d = t_delta(m_idx, int'(c[2:0]));
      m_acc = c[3] ? (m_acc - 16'(d)) : (m_acc + 16'(d));
      m_idx = m_idx + t_adj(int'(c[2:0]));
      if (m_idx < 0) m_idx = 0;
      if (m_idx > 15) m_idx = 15;
    end
  endtask

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: sample_out actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive at a falling edge, capture on the rising edge, check on the next falling edge.
  task automatic step(input logic v, input logic [3:0] c, input logic clr, input string tag);
    code_valid = v;
    code       = c;
    clear      = clr;
    @(negedge clk);
    model_apply(v, c, clr);
    check(tag, sample_out, t_out(m_acc));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    code_valid = 1'b0;
    clear = 1'b0;
    code = 4'h0;
    #1;
    // R1: output is zero while reset is asserted
    check("R1", sample_out, 16'h0000);
    m_acc = '0;
    m_idx = 0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    logic [3:0]  rc;
    logic        rv, rclr;
    int          bias;
    checks = 0;
    fails  = 0;
    void'($urandom(32'd20240611));
    @(negedge clk);
    do_reset();
    check("R1", sample_out, 16'h0000);

    // R3 row 0 anchor and R6: magnitude 7 at index 0 gives +10.
    step(1'b1, 4'h7, 1'b0, "R6");
    check("R3", sample_out, 16'(10 * 128));
    // R2: the negative code reverses the delta; R4 index moved to 3 before this code.
    prev = sample_out;
    step(1'b1, 4'hF, 1'b0, "R2");
    check("R2", 16'(prev - sample_out), 16'(t_delta(3, 7) * 128));

    // R10: idle cycles with changing code leave the output unchanged.
    for (int k = 0; k < 4; k++) step(1'b0, 4'(k * 5), 1'b0, "R10");

    // R5: drive the index to the upper limit, then past it.
    for (int k = 0; k < 10; k++) step(1'b1, (k % 2 == 0) ? 4'h7 : 4'hF, 1'b0, "R5");
    prev = sample_out;
    step(1'b1, 4'h7, 1'b0, "R5");
    check("R3", 16'(sample_out - prev), 16'(214 * 128));

    // R7: clear zeroes sample and index.
    step(1'b0, 4'h0, 1'b1, "R7");
    check("R7", sample_out, 16'h0000);
    step(1'b1, 4'h6, 1'b0, "R7");
    check("R7", sample_out, 16'(7 * 128));

    // R5: drive the index to the lower limit, then past it.
    for (int k = 0; k < 8; k++) step(1'b1, 4'h8, 1'b0, "R5");
    prev = sample_out;
    step(1'b1, 4'h1, 1'b0, "R5");
    check("R5", sample_out, prev);

    // R8: clear and strobe together; the clear wins.
    step(1'b1, 4'h7, 1'b0, "R8");
    step(1'b1, 4'h7, 1'b1, "R8");
    check("R8", sample_out, 16'h0000);

    // R9: long positive run so the accumulator wraps.
    for (int k = 0; k < 400; k++) step(1'b1, 4'h7, 1'b0, "R9");

    // Random streams biased toward both clamp limits.
    for (int blk = 0; blk < 40; blk++) begin
      bias = blk % 3;
      for (int k = 0; k < 100; k++) begin
        rv   = ($urandom % 10) < 8;
        rclr = ($urandom % 100) < 2;
        rc   = 4'($urandom);
        if (bias == 0) rc[2] = 1'b1;
        else if (bias == 1) rc[2:1] = 2'b00;
        step(rv, rc, rclr, "R3");
      end
    end

    // R1: reset in mid-run brings the output back to zero.
    do_reset();
    check("R1", sample_out, 16'h0000);
    step(1'b1, 4'h5, 1'b0, "R1");
    check("R1", sample_out, 16'(5 * 128));

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule